// File: doc/BRIEF.md
# DMA Channel Register File

This block is the control and status register bank of a multichannel memory-access layer that feeds network DMA channels. A processor reaches it through a device-control register port: a register number, a write strobe with write data, and a combinational read-data return for whatever number is currently presented. The block holds a global configuration word, an interrupt-enable mask, channel-active set and reset words for each direction, and five status words that the datapath sets bit by bit and software clears by writing ones.

Beside the global registers, the block keeps one descriptor-table pointer for every transmit channel, one for every receive channel, and one receive buffer size for every receive channel. The transmit and receive channel counts are parameters, each between 1 and 32, and they size these per-channel windows. A configuration write with its top bit set acts as a software reset of the status and enable state. Descriptor fetching, data movement and interrupt-line generation are left to neighbouring blocks, which read the stored values from the output ports.

Top module: `chreg_bank`

## Requirements
- R1: After hardware reset, configuration reads 0x0007C000, and interrupt enable, both active-set words, both active-reset words and all five status words read zero.
- R2: Register numbers: configuration 0x180, error status 0x181, interrupt enable 0x182, transmit active set 0x184, transmit active reset 0x185, transmit end-of-buffer status 0x186, transmit descriptor-error status 0x187, receive active set 0x190, receive active reset 0x191, receive end-of-buffer status 0x192, receive descriptor-error status 0x193; transmit pointer n at 0x1A0+n, receive pointer n at 0x1C0+n, receive buffer size n at 0x1E0+n.
- R3: A configuration write stores the write data ANDed with 0x00FFC087, so bit 31 never reads back as one.
- R4: A configuration write with bit 31 set clears error status, interrupt enable, both active-set words and all four end-of-buffer and descriptor-error statuses in the same cycle; the active-reset words, pointers and buffer sizes keep their values.
- R5: Error status and the four end-of-buffer and descriptor-error statuses are write-one-to-clear: each written one clears that bit, each written zero leaves it.
- R6: When a hardware set input and a clearing write (one-to-clear or software reset) reach the same status bit in the same cycle, the bit ends up set.
- R7: Interrupt enable stores only write-data bits [4:0]; the rest read as zero.
- R8: Transmit active set and reset store only bits [31:28]; receive active set and reset store only bits [31:30].
- R9: Channel pointers store all 32 bits; receive buffer sizes store only bits [7:0]; neither changes except by a write to its own number.
- R10: Reads of numbers that map to no register, including per-channel numbers at or beyond the configured channel count, return zero, and writes to them change no register.
- R11: Error status is 32 bits, one set input per bit; in each end-of-buffer and descriptor-error status, bit n belongs to channel n and is set by set-input bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_num | input | 10 | Register number for read and write |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register at acc_num |
| err_set_i | input | 32 | Per-bit set of error status |
| tx_eob_set_i | input | TXN | Per-channel set of transmit end-of-buffer status |
| tx_derr_set_i | input | TXN | Per-channel set of transmit descriptor-error status |
| rx_eob_set_i | input | RXN | Per-channel set of receive end-of-buffer status |
| rx_derr_set_i | input | RXN | Per-channel set of receive descriptor-error status |
| cfg_o | output | 32 | Stored configuration |
| ien_o | output | 5 | Stored interrupt enable |
| tx_act_set_o | output | 32 | Transmit active-set word |
| tx_act_clr_o | output | 32 | Transmit active-reset word |
| rx_act_set_o | output | 32 | Receive active-set word |
| rx_act_clr_o | output | 32 | Receive active-reset word |
| err_o | output | 32 | Error status |
| tx_eob_o | output | TXN | Transmit end-of-buffer status |
| tx_derr_o | output | TXN | Transmit descriptor-error status |
| rx_eob_o | output | RXN | Receive end-of-buffer status |
| rx_derr_o | output | RXN | Receive descriptor-error status |
| tx_ptr_o | output | 32*TXN | Transmit descriptor-table pointers, channel n in bits [32n+31:32n] |
| rx_ptr_o | output | 32*RXN | Receive descriptor-table pointers, channel n in bits [32n+31:32n] |
| rx_bsz_o | output | 8*RXN | Receive buffer sizes, channel n in bits [8n+7:8n] |

## Verification
The collision that matters is a datapath set pulse on a status bit landing in the same cycle as software clearing that bit, either by a one-to-clear write to the status number or by a configuration write carrying the reset bit. The bench first fills a status word through the set inputs, then drives the set input and the clearing write on the same clock edge, and reads the word back on the following cycle: the pulsed bit must read one while the other written-one bits read zero.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

   localparam int unsigned NUM_W  = 10;
   localparam int unsigned DATA_W = 32;

   typedef logic [NUM_W-1:0]  regnum_t;
   typedef logic [DATA_W-1:0] word_t;

   // register numbers (software-visible, fixed)
   localparam regnum_t RN_CFG   = 10'h180;
   localparam regnum_t RN_ERR   = 10'h181;
   localparam regnum_t RN_IEN   = 10'h182;
   localparam regnum_t RN_TXSET = 10'h184;
   localparam regnum_t RN_TXCLR = 10'h185;
   localparam regnum_t RN_TXEOB = 10'h186;
   localparam regnum_t RN_TXDER = 10'h187;
   localparam regnum_t RN_RXSET = 10'h190;
   localparam regnum_t RN_RXCLR = 10'h191;
   localparam regnum_t RN_RXEOB = 10'h192;
   localparam regnum_t RN_RXDER = 10'h193;
   localparam regnum_t RN_TXPTR = 10'h1A0;
   localparam regnum_t RN_RXPTR = 10'h1C0;
   localparam regnum_t RN_RXBSZ = 10'h1E0;

   // storage masks and initial values
   localparam word_t CFG_KEEP   = 32'h00FF_C087;
   localparam word_t CFG_INIT   = 32'h0007_C000;
   localparam int unsigned CFG_SWRST = 31;
   localparam int unsigned IEN_W     = 5;
   localparam word_t TXACT_KEEP = 32'hF000_0000;
   localparam word_t RXACT_KEEP = 32'hC000_0000;
   localparam int unsigned BSZ_W     = 8;
   localparam int unsigned MAX_CHAN  = 32;

   typedef struct packed {
      logic cfg;
      logic err;
      logic ien;
      logic txset;
      logic txclr;
      logic txeob;
      logic txder;
      logic rxset;
      logic rxclr;
      logic rxeob;
      logic rxder;
   } glob_hit_t;

endpackage

// File: rtl/chreg_decode.sv
module chreg_decode
   import chreg_pkg::*;
#(
   parameter int unsigned TXN = 4,
   parameter int unsigned RXN = 2
) (
   input  regnum_t        num,
   output glob_hit_t      ghit,
   output logic [TXN-1:0] txptr_hit,
   output logic [RXN-1:0] rxptr_hit,
   output logic [RXN-1:0] rxbsz_hit
);

   always_comb begin
      ghit       = '0;
      ghit.cfg   = (num == RN_CFG);
      ghit.err   = (num == RN_ERR);
      ghit.ien   = (num == RN_IEN);
      ghit.txset = (num == RN_TXSET);
      ghit.txclr = (num == RN_TXCLR);
      ghit.txeob = (num == RN_TXEOB);
      ghit.txder = (num == RN_TXDER);
      ghit.rxset = (num == RN_RXSET);
      ghit.rxclr = (num == RN_RXCLR);
      ghit.rxeob = (num == RN_RXEOB);
      ghit.rxder = (num == RN_RXDER);
   end

   // per-channel windows: only numbers below the channel count decode
   for (genvar t = 0; t < TXN; t++) begin : g_tx
      localparam regnum_t TX_NUM = regnum_t'(RN_TXPTR + t);
      assign txptr_hit[t] = (num == TX_NUM);
   end

   for (genvar r = 0; r < RXN; r++) begin : g_rx
      localparam regnum_t RXP_NUM = regnum_t'(RN_RXPTR + r);
      localparam regnum_t RXB_NUM = regnum_t'(RN_RXBSZ + r);
      assign rxptr_hit[r] = (num == RXP_NUM);
      assign rxbsz_hit[r] = (num == RXB_NUM);
   end

endmodule

// File: rtl/chreg_w1c.sv
module chreg_w1c #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);

   logic [W-1:0] kept;
   logic [W-1:0] q_nxt;

   // hardware set is ORed last, so it overrides any clear in the same cycle
   always_comb begin
      if (soft_clr)
         kept = '0;
      else if (clr_we)
         kept = q & ~clr_mask;
      else
         kept = q;
      q_nxt = kept | set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= q_nxt;
   end

endmodule

// File: rtl/chreg_field.sv
module chreg_field #(
   parameter int unsigned    W       = 32,
   parameter logic [W-1:0]   INIT    = '0,
   parameter bit             SOFT_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (SOFT_RST) begin : g_soft
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= INIT;
         else if (soft_clr)
            q <= INIT;
         else if (we)
            q <= d;
      end
   end else begin : g_hard
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= INIT;
         else if (we)
            q <= d;
      end
   end

endmodule

// File: rtl/chreg_ptr_array.sv
module chreg_ptr_array #(
   parameter int unsigned N = 4,
   parameter int unsigned W = 32
) (
   input  logic           clk,
   input  logic [N-1:0]   we,
   input  logic [W-1:0]   d,
   output logic [N*W-1:0] q
);

   // pointers and sizes carry no reset: software loads them before use
   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (we[i])
            q[i*W +: W] <= d;
      end
   end

endmodule

// File: rtl/chreg_bank.sv
module chreg_bank
   import chreg_pkg::*;
#(
   parameter int unsigned TXN = 4,
   parameter int unsigned RXN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [9:0]        acc_num,
   input  logic              acc_wr,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       rd_data,
   input  logic [31:0]       err_set_i,
   input  logic [TXN-1:0]    tx_eob_set_i,
   input  logic [TXN-1:0]    tx_derr_set_i,
   input  logic [RXN-1:0]    rx_eob_set_i,
   input  logic [RXN-1:0]    rx_derr_set_i,
   output logic [31:0]       cfg_o,
   output logic [4:0]        ien_o,
   output logic [31:0]       tx_act_set_o,
   output logic [31:0]       tx_act_clr_o,
   output logic [31:0]       rx_act_set_o,
   output logic [31:0]       rx_act_clr_o,
   output logic [31:0]       err_o,
   output logic [TXN-1:0]    tx_eob_o,
   output logic [TXN-1:0]    tx_derr_o,
   output logic [RXN-1:0]    rx_eob_o,
   output logic [RXN-1:0]    rx_derr_o,
   output logic [32*TXN-1:0] tx_ptr_o,
   output logic [32*RXN-1:0] rx_ptr_o,
   output logic [8*RXN-1:0]  rx_bsz_o
);

   localparam int unsigned PTR_W = DATA_W;

   if (TXN < 1 || TXN > MAX_CHAN) begin : g_bad_txn
      $error("chreg_bank: TXN must be 1..32");
   end
   if (RXN < 1 || RXN > MAX_CHAN) begin : g_bad_rxn
      $error("chreg_bank: RXN must be 1..32");
   end

   glob_hit_t      ghit;
   logic [TXN-1:0] txptr_hit;
   logic [RXN-1:0] rxptr_hit;
   logic [RXN-1:0] rxbsz_hit;
   logic           soft_clr;
   logic [IEN_W-1:0] ien_q;

   chreg_decode #(.TXN(TXN), .RXN(RXN)) u_dec (
      .num       (acc_num),
      .ghit      (ghit),
      .txptr_hit (txptr_hit),
      .rxptr_hit (rxptr_hit),
      .rxbsz_hit (rxbsz_hit)
   );

   assign soft_clr = acc_wr & ghit.cfg & acc_wdata[CFG_SWRST];

   // configuration: the reset bit itself is never stored
   chreg_field #(.W(DATA_W), .INIT(CFG_INIT), .SOFT_RST(1'b0)) u_cfg (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .we  (acc_wr & ghit.cfg), .d (acc_wdata & CFG_KEEP), .q (cfg_o)
   );

   chreg_field #(.W(IEN_W), .INIT('0), .SOFT_RST(1'b1)) u_ien (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .we  (acc_wr & ghit.ien), .d (acc_wdata[IEN_W-1:0]), .q (ien_q)
   );
   assign ien_o = ien_q;

   chreg_field #(.W(DATA_W), .INIT('0), .SOFT_RST(1'b1)) u_txset (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .we  (acc_wr & ghit.txset), .d (acc_wdata & TXACT_KEEP), .q (tx_act_set_o)
   );

   chreg_field #(.W(DATA_W), .INIT('0), .SOFT_RST(1'b0)) u_txclr (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .we  (acc_wr & ghit.txclr), .d (acc_wdata & TXACT_KEEP), .q (tx_act_clr_o)
   );

   chreg_field #(.W(DATA_W), .INIT('0), .SOFT_RST(1'b1)) u_rxset (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .we  (acc_wr & ghit.rxset), .d (acc_wdata & RXACT_KEEP), .q (rx_act_set_o)
   );

   chreg_field #(.W(DATA_W), .INIT('0), .SOFT_RST(1'b0)) u_rxclr (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .we  (acc_wr & ghit.rxclr), .d (acc_wdata & RXACT_KEEP), .q (rx_act_clr_o)
   );

   // write-one-to-clear status words
   chreg_w1c #(.W(DATA_W)) u_err (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .clr_we (acc_wr & ghit.err), .clr_mask (acc_wdata),
      .set (err_set_i), .q (err_o)
   );

   chreg_w1c #(.W(TXN)) u_txeob (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .clr_we (acc_wr & ghit.txeob), .clr_mask (acc_wdata[TXN-1:0]),
      .set (tx_eob_set_i), .q (tx_eob_o)
   );

   chreg_w1c #(.W(TXN)) u_txder (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .clr_we (acc_wr & ghit.txder), .clr_mask (acc_wdata[TXN-1:0]),
      .set (tx_derr_set_i), .q (tx_derr_o)
   );

   chreg_w1c #(.W(RXN)) u_rxeob (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .clr_we (acc_wr & ghit.rxeob), .clr_mask (acc_wdata[RXN-1:0]),
      .set (rx_eob_set_i), .q (rx_eob_o)
   );

   chreg_w1c #(.W(RXN)) u_rxder (
      .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr),
      .clr_we (acc_wr & ghit.rxder), .clr_mask (acc_wdata[RXN-1:0]),
      .set (rx_derr_set_i), .q (rx_derr_o)
   );

   // per-channel arrays
   chreg_ptr_array #(.N(TXN), .W(PTR_W)) u_txptr (
      .clk (clk), .we (txptr_hit & {TXN{acc_wr}}), .d (acc_wdata), .q (tx_ptr_o)
   );

   chreg_ptr_array #(.N(RXN), .W(PTR_W)) u_rxptr (
      .clk (clk), .we (rxptr_hit & {RXN{acc_wr}}), .d (acc_wdata), .q (rx_ptr_o)
   );

   chreg_ptr_array #(.N(RXN), .W(BSZ_W)) u_rxbsz (
      .clk (clk), .we (rxbsz_hit & {RXN{acc_wr}}), .d (acc_wdata[BSZ_W-1:0]),
      .q (rx_bsz_o)
   );

   // read return: OR of all selected sources, zero when nothing decodes
   always_comb begin
      rd_data = '0;
      if (ghit.cfg)   rd_data |= cfg_o;
      if (ghit.err)   rd_data |= err_o;
      if (ghit.ien)   rd_data |= 32'(ien_q);
      if (ghit.txset) rd_data |= tx_act_set_o;
      if (ghit.txclr) rd_data |= tx_act_clr_o;
      if (ghit.txeob) rd_data |= 32'(tx_eob_o);
      if (ghit.txder) rd_data |= 32'(tx_derr_o);
      if (ghit.rxset) rd_data |= rx_act_set_o;
      if (ghit.rxclr) rd_data |= rx_act_clr_o;
      if (ghit.rxeob) rd_data |= 32'(rx_eob_o);
      if (ghit.rxder) rd_data |= 32'(rx_derr_o);
      for (int t = 0; t < TXN; t++)
         if (txptr_hit[t]) rd_data |= tx_ptr_o[t*PTR_W +: PTR_W];
      for (int r = 0; r < RXN; r++) begin
         if (rxptr_hit[r]) rd_data |= rx_ptr_o[r*PTR_W +: PTR_W];
         if (rxbsz_hit[r]) rd_data |= 32'(rx_bsz_o[r*BSZ_W +: BSZ_W]);
      end
   end

endmodule

// File: rtl/chreg_bank_chk.sv
module chreg_bank_chk
   import chreg_pkg::*;
#(
   parameter int unsigned TXN = 4,
   parameter int unsigned RXN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [9:0]        acc_num,
   input logic              acc_wr,
   input logic [31:0]       acc_wdata,
   input logic [31:0]       rd_data,
   input logic [TXN-1:0]    tx_eob_set_i,
   input logic [RXN-1:0]    rx_eob_set_i,
   input logic [31:0]       cfg_o,
   input logic [4:0]        ien_o,
   input logic [31:0]       tx_act_set_o,
   input logic [TXN-1:0]    tx_eob_o,
   input logic [RXN-1:0]    rx_eob_o,
   input logic [32*TXN-1:0] tx_ptr_o
);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_eob_set_i) |=> ((tx_eob_o & $past(tx_eob_set_i)) == $past(tx_eob_set_i))); // R6

   AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_num == RN_RXEOB && rx_eob_set_i == '0)
      |=> (rx_eob_o == ($past(rx_eob_o) & ~$past(acc_wdata[RXN-1:0])))); // R5

   AST_IEN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_num == RN_IEN) |=> (ien_o == $past(acc_wdata[4:0]))); // R7

   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_num == RN_CFG && acc_wdata[31])
      |=> (cfg_o == ($past(acc_wdata) & CFG_KEEP) && tx_act_set_o == '0 && ien_o == '0)); // R4

   AST_CFG_NO_SWRST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_num == RN_CFG) |=> !cfg_o[31]); // R3

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_num == 10'h183) |-> (rd_data == '0)); // R10

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_wr) |=> $stable(tx_ptr_o)); // R9

endmodule

bind chreg_bank chreg_bank_chk #(.TXN(TXN), .RXN(RXN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_num      (acc_num),
   .acc_wr       (acc_wr),
   .acc_wdata    (acc_wdata),
   .rd_data      (rd_data),
   .tx_eob_set_i (tx_eob_set_i),
   .rx_eob_set_i (rx_eob_set_i),
   .cfg_o        (cfg_o),
   .ien_o        (ien_o),
   .tx_act_set_o (tx_act_set_o),
   .tx_eob_o     (tx_eob_o),
   .rx_eob_o     (rx_eob_o),
   .tx_ptr_o     (tx_ptr_o)
);

// File: tb/chreg_bank_test.sv
module chreg_bank_test;

   localparam int unsigned TXN = 4;
   localparam int unsigned RXN = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [9:0]        acc_num = '0;
   logic              acc_wr = 1'b0;
   logic [31:0]       acc_wdata = '0;
   logic [31:0]       rd_data;
   logic [31:0]       err_set_i = '0;
   logic [TXN-1:0]    tx_eob_set_i = '0;
   logic [TXN-1:0]    tx_derr_set_i = '0;
   logic [RXN-1:0]    rx_eob_set_i = '0;
   logic [RXN-1:0]    rx_derr_set_i = '0;
   logic [31:0]       cfg_o;
   logic [4:0]        ien_o;
   logic [31:0]       tx_act_set_o, tx_act_clr_o, rx_act_set_o, rx_act_clr_o;
   logic [31:0]       err_o;
   logic [TXN-1:0]    tx_eob_o, tx_derr_o;
   logic [RXN-1:0]    rx_eob_o, rx_derr_o;
   logic [32*TXN-1:0] tx_ptr_o;
   logic [32*RXN-1:0] rx_ptr_o;
   logic [8*RXN-1:0]  rx_bsz_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   chreg_bank #(.TXN(TXN), .RXN(RXN)) uut (
      .clk (clk), .rst_n (rst_n), .acc_num (acc_num), .acc_wr (acc_wr),
      .acc_wdata (acc_wdata), .rd_data (rd_data), .err_set_i (err_set_i),
      .tx_eob_set_i (tx_eob_set_i), .tx_derr_set_i (tx_derr_set_i),
      .rx_eob_set_i (rx_eob_set_i), .rx_derr_set_i (rx_derr_set_i),
      .cfg_o (cfg_o), .ien_o (ien_o), .tx_act_set_o (tx_act_set_o),
      .tx_act_clr_o (tx_act_clr_o), .rx_act_set_o (rx_act_set_o),
      .rx_act_clr_o (rx_act_clr_o), .err_o (err_o), .tx_eob_o (tx_eob_o),
      .tx_derr_o (tx_derr_o), .rx_eob_o (rx_eob_o), .rx_derr_o (rx_derr_o),
      .tx_ptr_o (tx_ptr_o), .rx_ptr_o (rx_ptr_o), .rx_bsz_o (rx_bsz_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] n, input logic [31:0] d);
      @(negedge clk);
      acc_num = n; acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [9:0] n, input logic [31:0] exp);
      acc_num = n;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic pulse_sets(input logic [31:0] e, input logic [TXN-1:0] te,
                             input logic [TXN-1:0] td, input logic [RXN-1:0] re,
                             input logic [RXN-1:0] rdr);
      @(negedge clk);
      err_set_i = e; tx_eob_set_i = te; tx_derr_set_i = td;
      rx_eob_set_i = re; rx_derr_set_i = rdr;
      @(negedge clk);
      err_set_i = '0; tx_eob_set_i = '0; tx_derr_set_i = '0;
      rx_eob_set_i = '0; rx_derr_set_i = '0;
   endtask

   task automatic t_reset_state;
      rd("R1 cfg", 10'h180, 32'h0007_C000);
      rd("R1 ien", 10'h182, 32'h0);
      rd("R1 txset", 10'h184, 32'h0);
      rd("R1 rxclr", 10'h191, 32'h0);
      rd("R1 err", 10'h181, 32'h0);
      rd("R1 txeob", 10'h186, 32'h0);
      rd("R1 rxder", 10'h193, 32'h0);
   endtask

   task automatic t_masks;
      wr(10'h180, 32'h7FFF_FFFF);
      rd("R3 cfg mask", 10'h180, 32'h00FF_C087);
      wr(10'h182, 32'hFFFF_FFFF);
      rd("R7 ien mask", 10'h182, 32'h0000_001F);
      wr(10'h184, 32'hFFFF_FFFF);
      rd("R8 txset mask", 10'h184, 32'hF000_0000);
      wr(10'h185, 32'h3FFF_FFFF);
      rd("R8 txclr mask", 10'h185, 32'h3000_0000);
      wr(10'h190, 32'hFFFF_FFFF);
      rd("R8 rxset mask", 10'h190, 32'hC000_0000);
      wr(10'h191, 32'h7FFF_FFFF);
      rd("R8 rxclr mask", 10'h191, 32'h4000_0000);
   endtask

   task automatic t_channel_arrays;
      for (int i = 0; i < TXN; i++) wr(10'(10'h1A0 + i), 32'hA5A5_0000 + 32'(i));
      for (int i = 0; i < RXN; i++) wr(10'(10'h1C0 + i), 32'hC3C3_0100 + 32'(i));
      for (int i = 0; i < RXN; i++) wr(10'(10'h1E0 + i), 32'hFFFF_FF40 + 32'(i));
      rd("R2 R9 txptr0", 10'h1A0, 32'hA5A5_0000);
      rd("R2 R9 txptr3", 10'h1A3, 32'hA5A5_0003);
      rd("R2 R9 rxptr1", 10'h1C1, 32'hC3C3_0101);
      rd("R9 rxbsz0 mask", 10'h1E0, 32'h0000_0040);
      rd("R9 rxbsz1 mask", 10'h1E1, 32'h0000_0041);
   endtask

   task automatic t_unmapped;
      rd("R10 read 0x183", 10'h183, 32'h0);
      wr(10'h1A4, 32'hDEAD_BEEF);
      rd("R10 tx window end", 10'h1A4, 32'h0);
      rd("R10 txptr3 untouched", 10'h1A3, 32'hA5A5_0003);
      wr(10'h1C2, 32'h1234_5678);
      rd("R10 rx window end", 10'h1C2, 32'h0);
      rd("R10 rxptr1 untouched", 10'h1C1, 32'hC3C3_0101);
      wr(10'h1E2, 32'h0000_00FF);
      rd("R10 bsz window end", 10'h1E2, 32'h0);
      rd("R10 bsz1 untouched", 10'h1E1, 32'h0000_0041);
   endtask

   task automatic t_status_w1c;
      pulse_sets(32'h8000_0001, 4'b0100, 4'b1001, 2'b10, 2'b01);
      rd("R11 err layout", 10'h181, 32'h8000_0001);
      rd("R11 txeob bit2", 10'h186, 32'h0000_0004);
      rd("R11 txder", 10'h187, 32'h0000_0009);
      rd("R11 rxeob bit1", 10'h192, 32'h0000_0002);
      rd("R11 rxder bit0", 10'h193, 32'h0000_0001);
      wr(10'h181, 32'h8000_0000);
      rd("R5 err partial clear", 10'h181, 32'h0000_0001);
      wr(10'h187, 32'h0000_0001);
      rd("R5 txder partial clear", 10'h187, 32'h0000_0008);
      wr(10'h192, 32'h0000_0000);
      rd("R5 zero write keeps", 10'h192, 32'h0000_0002);
      wr(10'h192, 32'hFFFF_FFFF);
      rd("R5 rxeob cleared", 10'h192, 32'h0);
   endtask

   task automatic t_set_vs_clear;
      pulse_sets(32'h0, 4'b1111, 4'b0000, 2'b00, 2'b00);
      rd("R6 preload", 10'h186, 32'h0000_000F);
      @(negedge clk);
      acc_num = 10'h186; acc_wdata = 32'h0000_000F; acc_wr = 1'b1;
      tx_eob_set_i = 4'b0001;
      @(negedge clk);
      acc_wr = 1'b0; tx_eob_set_i = '0;
      rd("R6 set beats w1c", 10'h186, 32'h0000_0001);
   endtask

   task automatic t_soft_reset;
      wr(10'h182, 32'h0000_0015);
      wr(10'h184, 32'hF000_0000);
      wr(10'h190, 32'hC000_0000);
      wr(10'h185, 32'h5000_0000);
      pulse_sets(32'h0000_0F00, 4'b0010, 4'b0100, 2'b01, 2'b10);
      @(negedge clk);
      acc_num = 10'h180; acc_wdata = 32'h8000_FFFF; acc_wr = 1'b1;
      rx_eob_set_i = 2'b10;
      @(negedge clk);
      acc_wr = 1'b0; rx_eob_set_i = '0;
      rd("R4 R3 cfg after swrst", 10'h180, 32'h0000_C087);
      rd("R4 ien cleared", 10'h182, 32'h0);
      rd("R4 txset cleared", 10'h184, 32'h0);
      rd("R4 rxset cleared", 10'h190, 32'h0);
      rd("R4 txclr kept", 10'h185, 32'h5000_0000);
      rd("R4 err cleared", 10'h181, 32'h0);
      rd("R4 txeob cleared", 10'h186, 32'h0);
      rd("R4 txder cleared", 10'h187, 32'h0);
      rd("R4 rxder cleared", 10'h193, 32'h0);
      rd("R6 set beats swrst", 10'h192, 32'h0000_0002);
      rd("R4 txptr kept", 10'h1A2, 32'hA5A5_0002);
      rd("R4 bsz kept", 10'h1E0, 32'h0000_0040);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_masks();
      t_channel_arrays();
      t_unmapped();
      t_status_w1c();
      t_set_vs_clear();
      t_soft_reset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule